// File: doc/BRIEF.md
# Dual-Buffer Snapshot Capture Sequencer

This block is the global timing controller for a pixel array in which every pixel holds two analog sample memories. It moves the whole array through each frame with one set of shared control lines, so every pixel is reset, exposed and sampled at the same instant. It never works row by row. The frame runs through five phases in a fixed order: reset, integration, storage, amplification and readout. All durations are counted in clock cycles.

In ping-pong mode each frame is stored into one memory, and the memory used swaps on every frame. Readout of a finished frame runs while the next frame is being reset, exposed and stored into the other memory. This raises the frame rate without shortening the exposure. In correlated-double-sampling mode one frame fills both memories: memory 0 just after reset and memory 1 at the end of integration. Both are then read in turn so that a downstream unit can take the difference. A retention monitor flags any memory that sits stored but unread for too long.

Top module: `snap_frame_seq`

## Requirements
- R1: While `rst_n` is low and afterwards with `run` low, `pix_rst` is 1, `store` and `read_en` are 0, `frame_valid` is 0 and `overrun` is 0.
- R2: `pix_rst` is high whenever the sequencer is idle. Counting the clock edge that first samples `run` high in idle as edge 1, `pix_rst` stays high through edge RST_CYC and is low from edge RST_CYC+1. No store strobe is ever high while `pix_rst` is high.
- R3: In ping-pong mode, with N integration cycles and M readout cycles, the single store strobe is high in the cycle after edge RST_CYC+N+1. Readout of that memory lasts exactly M cycles and starts after edge RST_CYC+N+3 when the reader is free.
- R4: Ping-pong frames store into memory 0 (`store[0]`) and memory 1 (`store[1]`) in turn, starting with memory 0 after `rst_n`. Each frame reads back its own memory. `frame_valid` is high exactly while a bit of `read_en` is high, and `rd_idx` gives that bit's index.
- R5: A memory is never strobed and read in the same cycle. At most one `store` bit and at most one `read_en` bit is high at a time.
- R6: With `run` held, the next frame's reset, integration and store run while the previous frame is read out. A frame whose amplification phase ends while the reader is busy waits there until the reader is free. No read cycle is lost.
- R7: In CDS mode `store[0]` pulses after edge RST_CYC+1 and `store[1]` after edge RST_CYC+N+2. Memory 0 is then read for M cycles from edge RST_CYC+N+4, followed directly by memory 1 for M cycles. The next frame starts only after both reads. A CDS frame does not change the ping-pong memory order, and its first store waits in reset while any earlier readout is still running.
- R8: The mode and both durations are captured when the reset phase is entered. Changing the inputs later has no effect until the next reset phase.
- R9: A programmed integration or readout length of 0 behaves as 1.
- R10: `overrun` goes high once a memory has been stored and left unread for more than RET_LIMIT cycles. It then stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start request; held high for back-to-back frames |
| cds_mode | input | 1 | 0 = ping-pong, 1 = correlated double sampling |
| int_cycles | input | CNT_W | Integration length in cycles |
| rd_cycles | input | CNT_W | Readout length per memory in cycles |
| pix_rst | output | 1 | Global pixel reset |
| store | output | 2 | Store strobe per memory |
| read_en | output | 2 | Readout enable per memory |
| frame_valid | output | 1 | A memory is being read |
| rd_idx | output | 1 | Index of the memory being read |
| overrun | output | 1 | Sticky retention-limit violation |

## Verification
On every cycle the assertions check the following: no store and read on the same memory, at most one strobe per group, no store during global reset, and that the overrun flag stays set once raised. The exact phase timing, the memory alternation, the CDS double strobe and readout order, and the capture of the configuration at reset can only be shown by the bench scenarios. The same holds for the overlap of one frame's capture with the previous frame's readout, and for an overrun caused by a long readout.

// File: rtl/snap_frame_seq.sv
module snap_frame_seq #(
  parameter int CNT_W     = 16,
  parameter int RST_CYC   = 4,
  parameter int RET_LIMIT = 2500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cds_mode,
  input  logic [CNT_W-1:0] int_cycles,
  input  logic [CNT_W-1:0] rd_cycles,
  output logic             pix_rst,
  output logic [1:0]       store,
  output logic [1:0]       read_en,
  output logic             frame_valid,
  output logic             rd_idx,
  output logic             overrun
);
  localparam int AGE_W = $clog2(RET_LIMIT + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PRE, S_INT, S_STO, S_AMP, S_DRAIN} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt, int_q, rd_q, rlen, rd_cnt;
  logic             cds_q, cap;
  logic             rd_busy, rd_mem, rd_more;
  logic [1:0]       pend;
  logic [AGE_W-1:0] age [2];

  wire rst_done  = (cnt == CNT_W'(RST_CYC - 1));
  wire launch    = (st == S_AMP) && !rd_busy;
  wire enter_rst = run && ((st == S_IDLE) ||
                           (launch && !cds_q) ||
                           (st == S_DRAIN && !rd_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= CNT_W'(1);
      rd_q  <= CNT_W'(1);
      cds_q <= 1'b0;
    end else if (enter_rst) begin
      int_q <= (int_cycles == '0) ? CNT_W'(1) : int_cycles;
      rd_q  <= (rd_cycles == '0) ? CNT_W'(1) : rd_cycles;
      cds_q <= cds_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      cap <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (run) begin st <= S_RST; cnt <= '0; end
        S_RST: begin
          if (rst_done && !(cds_q && rd_busy)) begin
            st  <= cds_q ? S_PRE : S_INT;
            cnt <= '0;
          end else if (!rst_done) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin st <= S_INT; cnt <= '0; end
        S_INT: begin
          if (cnt == int_q - 1'b1) begin st <= S_STO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_STO: st <= S_AMP;
        S_AMP: begin
          if (!rd_busy) begin
            if (!cds_q) cap <= ~cap;
            st  <= cds_q ? S_DRAIN : (run ? S_RST : S_IDLE);
            cnt <= '0;
          end
        end
        S_DRAIN: begin
          if (!rd_busy) begin st <= run ? S_RST : S_IDLE; cnt <= '0; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_mem  <= 1'b0;
      rd_more <= 1'b0;
      rd_cnt  <= '0;
      rlen    <= CNT_W'(1);
    end else if (launch) begin
      rd_busy <= 1'b1;
      rd_mem  <= cds_q ? 1'b0 : cap;
      rd_more <= cds_q;
      rd_cnt  <= '0;
      rlen    <= rd_q;
    end else if (rd_busy) begin
      if (rd_cnt == rlen - 1'b1) begin
        rd_cnt <= '0;
        if (rd_more) begin
          rd_mem  <= 1'b1;
          rd_more <= 1'b0;
        end else begin
          rd_busy <= 1'b0;
        end
      end else begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  assign pix_rst     = (st == S_IDLE) || (st == S_RST);
  assign store[0]    = (st == S_PRE) || (st == S_STO && !cds_q && !cap);
  assign store[1]    = (st == S_STO) && (cds_q || cap);
  assign read_en     = rd_busy ? (rd_mem ? 2'b10 : 2'b01) : 2'b00;
  assign frame_valid = rd_busy;
  assign rd_idx      = rd_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      age[0]  <= '0;
      age[1]  <= '0;
      overrun <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (store[i]) begin
          pend[i] <= 1'b1;
          age[i]  <= '0;
        end else if (read_en[i]) begin
          pend[i] <= 1'b0;
        end else if (pend[i]) begin
          if (age[i] < AGE_W'(RET_LIMIT)) age[i] <= age[i] + 1'b1;
          if (age[i] >= AGE_W'(RET_LIMIT)) overrun <= 1'b1;
        end
      end
    end
  end

  p_store_read_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (store & read_en) == 2'b00);
  p_store_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store));
  p_read_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(read_en));
  p_no_store_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst |-> (store == 2'b00));
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: tb/test_snap_frame_seq.sv
`timescale 1ns/1ps
module test_snap_frame_seq;
  localparam int CW = 16;
  localparam int RC = 4;
  localparam int RL = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cds_mode = 1'b0;
  logic [CW-1:0] int_cycles = '0;
  logic [CW-1:0] rd_cycles = '0;
  logic pix_rst, frame_valid, rd_idx, overrun;
  logic [1:0] store, read_en;

  int tests = 0;
  int fails = 0;
  int excl_bad = 0;
  int exp_cap = 0;

  always #4 clk = ~clk;

  snap_frame_seq #(.CNT_W(CW), .RST_CYC(RC), .RET_LIMIT(RL)) i_snap_frame_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .cds_mode(cds_mode),
    .int_cycles(int_cycles), .rd_cycles(rd_cycles), .pix_rst(pix_rst),
    .store(store), .read_en(read_en), .frame_valid(frame_valid),
    .rd_idx(rd_idx), .overrun(overrun));

  // vector: {cds, int_len, rd_len}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'd3,  8'd2},
    {1'b0, 8'd7,  8'd5},
    {1'b1, 8'd4,  8'd3},
    {1'b0, 8'd0,  8'd1},
    {1'b1, 8'd1,  8'd0},
    {1'b0, 8'd12, 8'd9}
  };

  always @(negedge clk) if (rst_n) begin
    if ((store & read_en) != 2'b00) excl_bad++;
    if ($countones(store) > 1 || $countones(read_en) > 1) excl_bad++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_rst == 1'b1, "R1 pix_rst", pix_rst, 1);
    chk(store == 2'b00 && read_en == 2'b00, "R1 strobes", {store, read_en}, 0);
    chk(frame_valid == 1'b0 && overrun == 1'b0, "R1 flags", {frame_valid, overrun}, 0);
    exp_cap = 0;
  endtask

  task automatic run_frame(input bit cds, input int iv, input int rv,
                           input int new_iv, output int got_sk);
    int n, m, lim, ns, rk, rlow, fvbad, c0, c1;
    int sk[2];
    int sv[2];
    n = (iv == 0) ? 1 : iv;
    m = (rv == 0) ? 1 : rv;
    lim = RC + n + 2 * m + 12;
    ns = 0; rk = -1; rlow = -1; fvbad = 0; c0 = 0; c1 = 0;
    sk[0] = -1; sk[1] = -1; sv[0] = 0; sv[1] = 0;
    @(negedge clk);
    cds_mode = cds; int_cycles = CW'(iv); rd_cycles = CW'(rv); run = 1'b1;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) run = 1'b0;
      if (k == 3 && new_iv >= 0) int_cycles = CW'(new_iv);
      if (!pix_rst && rlow < 0) rlow = k;
      if (store != 2'b00 && ns < 2) begin sk[ns] = k; sv[ns] = int'(store); ns++; end
      if (frame_valid && rk < 0) rk = k;
      if (read_en[0]) c0++;
      if (read_en[1]) c1++;
      if (frame_valid != (read_en != 2'b00)) fvbad++;
      if (frame_valid && !read_en[rd_idx]) fvbad++;
    end
    got_sk = sk[0];
    chk(rlow == RC + 1, "R2 reset length", rlow, RC + 1);
    chk(pix_rst && !frame_valid, "R2 back to idle", {pix_rst, frame_valid}, 2);
    chk(fvbad == 0, "R4 frame_valid/rd_idx", fvbad, 0);
    if (!cds) begin
      chk(ns == 1, "R3 store count", ns, 1);
      chk(sk[0] == RC + n + 1, "R3 R9 store cycle", sk[0], RC + n + 1);
      chk(sv[0] == (exp_cap ? 2 : 1), "R4 store memory", sv[0], exp_cap ? 2 : 1);
      chk(rk == RC + n + 3, "R3 read start", rk, RC + n + 3);
      chk((exp_cap ? c1 : c0) == m && (exp_cap ? c0 : c1) == 0, "R3 R4 R9 read length",
          exp_cap ? c1 : c0, m);
      exp_cap = 1 - exp_cap;
    end else begin
      chk(ns == 2, "R7 store count", ns, 2);
      chk(sk[0] == RC + 1 && sv[0] == 1, "R7 first store", sk[0], RC + 1);
      chk(sk[1] == RC + n + 2 && sv[1] == 2, "R7 R9 second store", sk[1], RC + n + 2);
      chk(rk == RC + n + 4, "R7 read start", rk, RC + n + 4);
      chk(c0 == m && c1 == m, "R7 R9 both reads", c0 + c1, 2 * m);
    end
  endtask

  initial begin
    #(8 * 60000);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int sk, ov, rd0, rd1, st0, st1;
    do_reset();

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1, sk);

    // R8: change the integration input mid-frame, then use it on the next frame
    run_frame(1'b0, 6, 2, 20, sk);
    chk(sk == RC + 7, "R8 old length kept", sk, RC + 7);
    run_frame(1'b0, 20, 2, -1, sk);
    chk(sk == RC + 21, "R8 new length used", sk, RC + 21);

    // R6: back-to-back ping-pong, capture overlaps readout
    ov = 0; rd0 = 0; rd1 = 0; st0 = 0; st1 = 0;
    @(negedge clk);
    cds_mode = 1'b0; int_cycles = 16'd5; rd_cycles = 16'd20; run = 1'b1;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 25) run = 1'b0;
      if (store != 2'b00 && read_en != 2'b00) ov++;
      if (store[0]) st0++;
      if (store[1]) st1++;
      if (read_en[0]) rd0++;
      if (read_en[1]) rd1++;
    end
    chk(ov > 0, "R6 store during readout", ov, 1);
    chk(st0 == 1 && st1 == 1, "R6 R4 both memories stored", st0 + st1, 2);
    chk(rd0 == 20 && rd1 == 20, "R6 no read lost", rd0 + rd1, 40);
    chk(overrun == 1'b0, "R10 no false overrun", overrun, 0);
    chk(excl_bad == 0, "R5 exclusive strobes", excl_bad, 0);

    // R10: long readout leaves the next memory unread too long
    do_reset();
    @(negedge clk);
    cds_mode = 1'b0; int_cycles = 16'd5; rd_cycles = 16'd60; run = 1'b1;
    for (int k = 1; k <= 220; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 25) run = 1'b0;
    end
    chk(overrun == 1'b1, "R10 overrun raised", overrun, 1);
    do_reset();
    chk(overrun == 1'b0, "R10 cleared by reset", overrun, 0);
    chk(excl_bad == 0, "R5 exclusive strobes end", excl_bad, 0);

    summary();
    $finish;
  end
endmodule